// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is a 32-bit integer multiply/divide unit that sits beside a processor datapath. It holds its results in two private registers, HI (upper word) and LO (lower word), which together form one 64-bit value. A requester starts an operation with a one-cycle strobe, an opcode and two operands. Multiplies run as a bit-serial shift-add loop that ends as soon as no set bits remain in the second operand's magnitude. Divides run a fixed-length restoring loop.

The requester reads the results back through a level-sensitive read port. If an operation is still in flight, the read is held off with a stall output. Writes to HI or LO from the requester follow a corruption rule: the first such write after an arithmetic result makes the other half unusable. Every "undefined" value is modelled as the fixed pattern 32'hDEADBEEF, so any corruption can be observed deterministically. No operation ever raises an exception.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and busy_o, stall_o and gpr_valid_o are low.
- R2: Opcode 0 (signed) and opcode 1 (unsigned) write the full 64-bit product of opa_i and opb_i, with HI taking bits 63:32 and LO taking bits 31:0.
- R3: Opcodes 2 (signed) and 3 (unsigned) add the 64-bit product to HI:LO. Opcodes 4 (signed) and 5 (unsigned) subtract the product from HI:LO. The result wraps modulo 2^64, and no error is signalled.
- R4: Opcode 6 (signed) and opcode 7 (unsigned) divide opa_i by opb_i. LO receives the quotient, truncated toward zero, and HI receives the remainder, which carries the dividend's sign. busy_o stays high for exactly 32 cycles.
- R5: A divide by zero, or a signed divide of 32'h80000000 by -1, sets both HI and LO to 32'hDEADBEEF.
- R6: Opcode 10 is a signed multiply. On its completion cycle, gpr_valid_o pulses high for one cycle with gpr_data_o equal to the low 32 bits of the product. HI and LO then both become 32'hDEADBEEF.
- R7: A multiply keeps busy_o high for max(1, n) cycles, where n is the bit length of opb_i's magnitude. The magnitude is the absolute value for signed opcodes and the raw value for unsigned opcodes.
- R8: Opcode 8 writes opa_i to HI and opcode 9 writes opa_i to LO, both at the accepting edge and without raising busy_o. The first such write after an arithmetic completion also sets the other register to 32'hDEADBEEF. Later writes change only their target.
- R9: While rd_hi_i or rd_lo_i is high and an operation is in flight, stall_o is high. With no stall, rdata_o shows HI when rd_hi_i is high and LO otherwise.
- R10: A start while busy_o is high is ignored. Opcodes 11 to 15 are also ignored: they leave HI and LO unchanged and do not raise busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 4 | Opcode |
| opa_i | input | 32 | First operand / move-to data |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Multiply or divide in flight |
| rd_hi_i | input | 1 | Read request for HI |
| rd_lo_i | input | 1 | Read request for LO |
| stall_o | output | 1 | Read request held off |
| rdata_o | output | 32 | Read data |
| gpr_valid_o | output | 1 | Three-operand multiply result strobe |
| gpr_data_o | output | 32 | Low product word for the general register |

## Verification
The assertions take for granted that all inputs are defined after reset. They also assume that the engines are started only through the unit's own acceptance logic, so an engine never sees a start while it is still busy. The stimulus changes every input on the falling clock edge and holds start_i high for one cycle per request. The only exception is one deliberate request overlapping a running divide. Move-to operands stay stable across the accepting edge.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    typedef enum logic [3:0] {
        OP_MULT  = 4'd0,
        OP_MULTU = 4'd1,
        OP_MADD  = 4'd2,
        OP_MADDU = 4'd3,
        OP_MSUB  = 4'd4,
        OP_MSUBU = 4'd5,
        OP_DIV   = 4'd6,
        OP_DIVU  = 4'd7,
        OP_MTHI  = 4'd8,
        OP_MTLO  = 4'd9,
        OP_MUL3  = 4'd10
    } op_e;
endpackage

// File: rtl/mul_iter.sv
module mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic          busy;
        logic          neg;
        logic [PW-1:0] mcand;
        logic [W-1:0]  mplier;
        logic [PW-1:0] acc;
    } mst_t;

    mst_t st_d, st_q;
    logic [W-1:0]  mag_a, mag_b, mpl_n;
    logic [PW-1:0] acc_n;

    always_comb begin
        mag_a  = (signed_i && a_i[W-1]) ? -a_i : a_i;
        mag_b  = (signed_i && b_i[W-1]) ? -b_i : b_i;
        acc_n  = st_q.acc + (st_q.mplier[0] ? st_q.mcand : '0);
        mpl_n  = st_q.mplier >> 1;
        done_o = st_q.busy && (mpl_n == '0);
        prod_o = st_q.neg ? -acc_n : acc_n;
        st_d   = st_q;
        if (start_i) begin
            st_d.busy   = 1'b1;
            st_d.neg    = signed_i && (a_i[W-1] ^ b_i[W-1]);
            st_d.mcand  = PW'(mag_a);
            st_d.mplier = mag_b;
            st_d.acc    = '0;
        end else if (st_q.busy) begin
            st_d.acc    = acc_n;
            st_d.mcand  = st_q.mcand << 1;
            st_d.mplier = mpl_n;
            if (done_o) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    // R7: each working cycle retires at least one multiplier bit
    a_r7_mul_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_o && !start_i) |=> (st_q.busy && (st_q.mplier < $past(st_q.mplier))));
endmodule

// File: rtl/div_iter.sv
module div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         bad_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          negq;
        logic          negr;
        logic          bad;
        logic [CW-1:0] cnt;
        logic [W-1:0]  dvs;
        logic [W-1:0]  rem;
        logic [W-1:0]  quot;
    } dst_t;

    dst_t st_d, st_q;
    logic [W-1:0] mag_a, mag_b, rem_n, quot_n;
    logic [W:0]   shifted, diff;
    logic         ge;

    always_comb begin
        mag_a   = (signed_i && a_i[W-1]) ? -a_i : a_i;
        mag_b   = (signed_i && b_i[W-1]) ? -b_i : b_i;
        shifted = {st_q.rem, st_q.quot[W-1]};
        diff    = shifted - {1'b0, st_q.dvs};
        ge      = shifted >= {1'b0, st_q.dvs};
        rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
        quot_n  = {st_q.quot[W-2:0], ge};
        done_o  = st_q.busy && (st_q.cnt == LAST);
        quo_o   = st_q.negq ? -quot_n : quot_n;
        rem_o   = st_q.negr ? -rem_n : rem_n;
        bad_o   = st_q.bad;
        st_d    = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.negq = signed_i && (a_i[W-1] ^ b_i[W-1]);
            st_d.negr = signed_i && a_i[W-1];
            st_d.bad  = (b_i == '0) ||
                        (signed_i && (a_i == {1'b1, {(W-1){1'b0}}}) && (b_i == '1));
            st_d.cnt  = '0;
            st_d.dvs  = mag_b;
            st_d.rem  = '0;
            st_d.quot = mag_a;
        end else if (st_q.busy) begin
            st_d.rem  = rem_n;
            st_d.quot = quot_n;
            st_d.cnt  = st_q.cnt + CW'(1);
            if (done_o) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    // R4: the step counter advances by one per cycle until the last step
    a_r4_div_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (st_q.cnt != LAST) && !start_i) |=> (st_q.busy && (st_q.cnt == $past(st_q.cnt) + CW'(1))));
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
    import hilo_pkg::*;
#(
    parameter int            W      = 32,
    parameter logic [W-1:0]  POISON = 32'hDEADBEEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    input  logic         rd_hi_i,
    input  logic         rd_lo_i,
    output logic         stall_o,
    output logic [W-1:0] rdata_o,
    output logic         gpr_valid_o,
    output logic [W-1:0] gpr_data_o
);
    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         fresh;
        op_e          kind;
    } ust_t;

    ust_t st_d, st_q;
    op_e  opc;
    logic is_mul, is_div, is_sgn, accept;
    logic mul_busy, mul_done, div_busy, div_done, div_bad;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;

    assign opc    = op_e'(op_i);
    assign is_mul = opc inside {OP_MULT, OP_MULTU, OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU, OP_MUL3};
    assign is_div = opc inside {OP_DIV, OP_DIVU};
    assign is_sgn = opc inside {OP_MULT, OP_MADD, OP_MSUB, OP_MUL3, OP_DIV};
    assign busy_o = mul_busy | div_busy;
    assign accept = start_i && !busy_o;

    mul_iter #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .start_i(accept && is_mul), .signed_i(is_sgn),
        .a_i(opa_i), .b_i(opb_i), .busy_o(mul_busy), .done_o(mul_done), .prod_o(prod)
    );

    div_iter #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(accept && is_div), .signed_i(is_sgn),
        .a_i(opa_i), .b_i(opb_i), .busy_o(div_busy), .done_o(div_done), .bad_o(div_bad),
        .quo_o(quo), .rem_o(rem)
    );

    always_comb begin
        st_d = st_q;
        if (mul_done) begin
            st_d.fresh = 1'b1;
            case (st_q.kind)
                OP_MADD, OP_MADDU: {st_d.hi, st_d.lo} = {st_q.hi, st_q.lo} + prod;
                OP_MSUB, OP_MSUBU: {st_d.hi, st_d.lo} = {st_q.hi, st_q.lo} - prod;
                OP_MUL3:           {st_d.hi, st_d.lo} = {POISON, POISON};
                default:           {st_d.hi, st_d.lo} = prod;
            endcase
        end
        if (div_done) begin
            st_d.fresh = 1'b1;
            st_d.hi    = div_bad ? POISON : rem;
            st_d.lo    = div_bad ? POISON : quo;
        end
        if (accept) begin
            case (opc)
                OP_MTHI: begin
                    st_d.hi    = opa_i;
                    st_d.lo    = st_q.fresh ? POISON : st_q.lo;
                    st_d.fresh = 1'b0;
                end
                OP_MTLO: begin
                    st_d.lo    = opa_i;
                    st_d.hi    = st_q.fresh ? POISON : st_q.hi;
                    st_d.fresh = 1'b0;
                end
                default: if (is_mul || is_div) st_d.kind = opc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hi: '0, lo: '0, fresh: 1'b0, kind: OP_MULT};
        else        st_q <= st_d;
    end

    assign stall_o     = (rd_hi_i | rd_lo_i) & busy_o;
    assign rdata_o     = rd_hi_i ? st_q.hi : st_q.lo;
    assign gpr_valid_o = mul_done && (st_q.kind == OP_MUL3);
    assign gpr_data_o  = prod[W-1:0];

    // R10: HI:LO hold still while an operation is in flight and not finishing
    a_r10_hilo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mul_done && !div_done) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R6: the general-register strobe lasts one cycle
    a_r6_gpr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid_o |=> !gpr_valid_o);

    // R8: first HI write after a result corrupts LO
    a_r8_first_mthi: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (opc == OP_MTHI) && st_q.fresh) |=> ((st_q.hi == $past(opa_i)) && (st_q.lo == POISON)));

    // R8: first LO write after a result corrupts HI
    a_r8_first_mtlo: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (opc == OP_MTLO) && st_q.fresh) |=> ((st_q.lo == $past(opa_i)) && (st_q.hi == POISON)));
endmodule

// File: tb/hilo_muldiv_unit_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_unit_bench;
    localparam logic [31:0] PZ = 32'hDEADBEEF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] opa = '0, opb = '0;
    logic busy, stall, gpr_valid;
    logic [31:0] rdata, gpr_data;
    int nchk = 0, nfail = 0;
    logic [63:0] m;

    always #2 clk = ~clk;

    hilo_muldiv_unit u_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .opa_i(opa), .opb_i(opb),
        .busy_o(busy), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .stall_o(stall), .rdata_o(rdata),
        .gpr_valid_o(gpr_valid), .gpr_data_o(gpr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] smul(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] x, y;
        x = {{32{a[31]}}, a};
        y = {{32{b[31]}}, b};
        return 64'(x * y);
    endfunction

    function automatic logic [63:0] umul(input logic [31:0] a, input logic [31:0] b);
        return {32'b0, a} * {32'b0, b};
    endfunction

    function automatic int blen(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) if (v[i]) n = i + 1;
        return (n == 0) ? 1 : n;
    endfunction

    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       output int cyc, output int gp, output logic [31:0] gd);
        @(negedge clk); start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk); start = 1'b0;
        cyc = 0; gp = 0; gd = '0;
        while (busy && cyc < 200) begin
            if (gpr_valid) begin gp++; gd = gpr_data; end
            @(negedge clk); cyc++;
        end
    endtask

    task automatic rdhl(output logic [63:0] v);
        @(negedge clk);
        rd_hi = 1'b1; #0.5; v[63:32] = rdata; rd_hi = 1'b0;
        rd_lo = 1'b1; #0.5; v[31:0]  = rdata; rd_lo = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        chk("R1 busy", {63'b0, busy}, 64'd0);
        chk("R1 stall", {63'b0, stall}, 64'd0);
        chk("R1 gpr_valid", {63'b0, gpr_valid}, 64'd0);
        rdhl(v);
        chk("R1 hilo", v, 64'd0);
    endtask

    task automatic t_mult;
        int c, g; logic [31:0] d; logic [63:0] v;
        run(4'd0, 32'hFFFFFFFD, 32'd7, c, g, d); rdhl(v);
        chk("R2 mult neg", v, smul(32'hFFFFFFFD, 32'd7));
        chk("R7 cycles 7", 64'(c), 64'(blen(32'd7)));
        run(4'd0, 32'h80000000, 32'h80000000, c, g, d); rdhl(v);
        chk("R2 mult min*min", v, 64'h4000000000000000);
        chk("R7 cycles min", 64'(c), 64'd32);
        run(4'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, c, g, d); rdhl(v);
        chk("R2 multu max", v, 64'hFFFFFFFE00000001);
        run(4'd0, 32'd12345, 32'd0, c, g, d); rdhl(v);
        chk("R2 mult zero", v, 64'd0);
        chk("R7 cycles zero", 64'(c), 64'd1);
        run(4'd0, 32'd9, 32'hFFFFFFF0, c, g, d);
        chk("R7 cycles neg16", 64'(c), 64'(blen(32'd16)));
    endtask

    task automatic t_accum;
        int c, g; logic [31:0] d; logic [63:0] v;
        run(4'd0, 32'd2, 32'd3, c, g, d);
        run(4'd8, 32'h00000001, 32'd0, c, g, d); rdhl(v);
        chk("R8 first mthi", v, {32'h00000001, PZ});
        chk("R8 no busy", 64'(c), 64'd0);
        run(4'd9, 32'hFFFFFFFF, 32'd0, c, g, d); rdhl(v);
        chk("R8 second mtlo", v, 64'h00000001FFFFFFFF);
        m = v;
        run(4'd2, 32'hFFFFFFFF, 32'd1, c, g, d); rdhl(v);
        m = m + smul(32'hFFFFFFFF, 32'd1);
        chk("R3 madd", v, m);
        run(4'd5, 32'hFFFFFFFF, 32'd2, c, g, d); rdhl(v);
        m = m - umul(32'hFFFFFFFF, 32'd2);
        chk("R3 msubu", v, m);
        run(4'd8, 32'hFFFFFFFF, 32'd0, c, g, d);
        run(4'd9, 32'hFFFFFFFF, 32'd0, c, g, d);
        run(4'd3, 32'd1, 32'd1, c, g, d); rdhl(v);
        chk("R3 maddu wrap", v, 64'd0);
        run(4'd4, 32'd3, 32'hFFFFFFFC, c, g, d); rdhl(v);
        chk("R3 msub", v, 64'd12);
        run(4'd9, 32'h12345678, 32'd0, c, g, d); rdhl(v);
        chk("R8 first mtlo", v, {PZ, 32'h12345678});
    endtask

    task automatic t_div;
        int c, g; logic [31:0] d; logic [63:0] v;
        logic signed [31:0] sa, sb;
        sa = -32'sd7; sb = 32'sd2;
        run(4'd6, sa, sb, c, g, d); rdhl(v);
        chk("R4 div signed", v, {32'(sa % sb), 32'(sa / sb)});
        chk("R4 div cycles", 64'(c), 64'd32);
        run(4'd7, 32'd100, 32'd7, c, g, d); rdhl(v);
        chk("R4 divu", v, {32'd2, 32'd14});
        sa = 32'sd100; sb = -32'sd9;
        run(4'd6, sa, sb, c, g, d); rdhl(v);
        chk("R4 div neg divisor", v, {32'(sa % sb), 32'(sa / sb)});
    endtask

    task automatic t_div_bad;
        int c, g; logic [31:0] d; logic [63:0] v;
        run(4'd6, 32'd5, 32'd0, c, g, d); rdhl(v);
        chk("R5 div by zero", v, {PZ, PZ});
        run(4'd7, 32'd5, 32'd0, c, g, d); rdhl(v);
        chk("R5 divu by zero", v, {PZ, PZ});
        run(4'd6, 32'h80000000, 32'hFFFFFFFF, c, g, d); rdhl(v);
        chk("R5 div overflow", v, {PZ, PZ});
    endtask

    task automatic t_mul3;
        int c, g; logic [31:0] d; logic [63:0] v;
        run(4'd10, 32'hFFFFFFFB, 32'd6, c, g, d); rdhl(v);
        chk("R6 gpr data", {32'd0, d}, {32'd0, 32'hFFFFFFE2});
        chk("R6 one pulse", 64'(g), 64'd1);
        chk("R6 hilo poisoned", v, {PZ, PZ});
    endtask

    task automatic t_stall_ignore;
        int c; logic [63:0] v;
        @(negedge clk); start = 1'b1; op = 4'd7; opa = 32'd1000; opb = 32'd10;
        @(negedge clk); op = 4'd9; opa = 32'h1111;
        rd_lo = 1'b1; #0.5;
        chk("R9 stall while busy", {63'b0, stall}, 64'd1);
        rd_lo = 1'b0;
        @(negedge clk); start = 1'b0;
        c = 1;
        while (busy && c < 200) begin @(negedge clk); c++; end
        chk("R4 divu cycles", 64'(c), 64'd32);
        #0.5;
        chk("R9 no stall idle", {63'b0, stall}, 64'd0);
        rdhl(v);
        chk("R10 start while busy ignored", v, {32'd0, 32'd100});
        begin
            int c2, g2; logic [31:0] d2;
            run(4'd12, 32'hAAAA5555, 32'd3, c2, g2, d2); rdhl(v);
            chk("R10 bad opcode no busy", 64'(c2), 64'd0);
            chk("R10 bad opcode hilo", v, {32'd0, 32'd100});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mult();
        t_accum();
        t_div();
        t_div_bad();
        t_mul3();
        t_stall_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule